// File: doc/BRIEF.md
# Programmable Event Counter Unit

This unit holds two 40-bit event counters for a processor performance-monitoring block. Each cycle, each counter receives a 4-bit count of occurrences of the event it has selected. It also receives a matching 4-bit count from the other cores and the current privilege level. The event code and unit mask written into a counter's control register are sent out to the event network, which returns the per-cycle counts. The counters themselves never see raw event signals.

A counter qualifies its per-cycle count in several ways. It can compare the count against a threshold, and it can invert that comparison. It can count only rising edges of the qualified condition. It can filter on privilege level, and it can add in the other cores' count. Some event codes are legal on only one counter. Software reads and writes the control words and both halves of each counter through a small register port. A counter that wraps sets a sticky status bit, which drives an interrupt line when that counter's interrupt enable is set. There is no chaining of the two counters.

Top module: `evtctr_unit`

## Requirements
- R1: After reset, every counter, control word, status bit and edge history is zero. `irq_o`, `sel_code_o` and `sel_umask_o` read as zero.
- R2: The register map is as follows. Address 0 is the control word of counter 0 and address 1 is the control word of counter 1. For counter i, address 2+2i holds count bits [31:0] and address 3+2i holds count bits [39:32] in data bits [7:0]. Address 6 is the status register, with bit i being the overflow of counter i. Writes to a count half leave the other half unchanged.
- R3: Control word layout: bits [7:0] event code, [15:8] unit mask, [19:16] threshold, 20 invert, 21 edge, 22 kernel-level enable, 23 user-level enable, 24 all-cores, 25 interrupt enable, 26 run. Counter i drives its event code on `sel_code_o[8i+7:8i]` and its unit mask on `sel_umask_o[8i+7:8i]`.
- R4: With threshold 0 and edge clear, a running counter adds its full per-cycle count each cycle. The invert bit has no effect in this case.
- R5: With a non-zero threshold and invert clear, the counter adds one in each cycle where the count is greater than or equal to the threshold.
- R6: With a non-zero threshold and invert set, the counter adds one in each cycle where the count is below the threshold.
- R7: With edge set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. The qualified condition is: count non-zero when the threshold is 0, otherwise the threshold compare.
- R8: Privilege level 0 counts only if the kernel-level bit is set. Levels 1 to 3 count only if the user-level bit is set. When both bits are clear, both levels count.
- R9: With all-cores set, the count is the local count plus the other-cores count, saturated at 15. With all-cores clear, only the local count is used.
- R10: Event codes 14H and C1H count only on counter 0. Codes 11H, 12H and 13H count only on counter 1. Selecting one of these on the other counter produces no counting.
- R11: A counter whose run bit is clear holds its value.
- R12: A counter step from all ones to zero sets its sticky status bit. Writing one to a status bit clears it. `irq_o[i]` is high while status bit i and counter i's interrupt enable are both set.
- R13: A software write to either half of a counter in the same cycle as a qualified increment takes effect, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| priv_i | input | 2 | Current privilege level, 0 to 3 |
| ev_local_i | input | 8 | Per-counter count of selected events on this core, 4 bits each |
| ev_other_i | input | 8 | Per-counter count of selected events on the other cores, 4 bits each |
| sel_code_o | output | 16 | Per-counter event code sent to the event network |
| sel_umask_o | output | 16 | Per-counter unit mask sent to the event network |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 2 | Per-counter overflow interrupt |

## Verification
A corrupted count, control word or status bit appears on `bus_rdata_o` in the same cycle its address is presented. A wrong status bit also reaches `irq_o` in that cycle. An error in the qualification path, such as a wrong threshold compare, a lost edge history or a wrong privilege decision, is invisible until software reads the count. The bench therefore runs each mode with a known input pattern and reads the exact total right after the pattern ends. A missed or extra single increment then shows as an off-by-one count.

// File: rtl/evtctr_pkg.sv
package evtctr_pkg;

    parameter int NCTR   = 2;
    parameter int CNT_W  = 40;
    parameter int EVW    = 4;
    parameter int CODE_W = 8;
    parameter int BUS_W  = 32;
    parameter int ADDR_W = 3;

    localparam int HI_W      = CNT_W - BUS_W;
    localparam int CTL_W     = 2 * CODE_W + EVW + 7;
    localparam int ADDR_CNT0 = NCTR;
    localparam int ADDR_STAT = NCTR + 2 * NCTR;

    typedef struct packed {
        logic              run;
        logic              irq_en;
        logic              wide;
        logic              user_lvl;
        logic              kern_lvl;
        logic              edge_md;
        logic              flip;
        logic [EVW-1:0]    thr;
        logic [CODE_W-1:0] mask;
        logic [CODE_W-1:0] evt;
    } ctl_t;

    typedef struct packed {
        ctl_t [NCTR-1:0]             ctl;
        logic [NCTR-1:0][CNT_W-1:0]  cnt;
        logic [NCTR-1:0]             ovf;
        logic [NCTR-1:0]             prev;
    } state_t;

    // Some event codes are legal on one counter only.
    function automatic logic code_allowed(input int idx, input logic [CODE_W-1:0] c);
        logic ok;
        case (c)
            8'h14, 8'hC1:        ok = (idx == 0);
            8'h11, 8'h12, 8'h13: ok = (idx == 1);
            default:             ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/evtctr_qual.sv
module evtctr_qual
    import evtctr_pkg::*;
#(
    parameter int IDX = 0
) (
    input  ctl_t           ctl_i,
    input  logic [1:0]     priv_i,
    input  logic [EVW-1:0] loc_i,
    input  logic [EVW-1:0] oth_i,
    input  logic           prev_i,
    output logic           qual_o,
    output logic [EVW-1:0] inc_o
);

    localparam logic [EVW-1:0] SAT = '1;

    logic [EVW:0]   sum_w;
    logic [EVW-1:0] cnt_w;
    logic           kern_ok, user_ok, priv_ok, legal, active, cond;

    always_comb begin
        sum_w = {1'b0, loc_i} + {1'b0, oth_i};
        if (ctl_i.wide) begin
            cnt_w = sum_w[EVW] ? SAT : sum_w[EVW-1:0];
        end else begin
            cnt_w = loc_i;
        end

        // both level bits clear means both levels count
        kern_ok = ctl_i.kern_lvl || !(ctl_i.kern_lvl || ctl_i.user_lvl);
        user_ok = ctl_i.user_lvl || !(ctl_i.kern_lvl || ctl_i.user_lvl);
        priv_ok = (priv_i == 2'd0) ? kern_ok : user_ok;

        legal  = code_allowed(IDX, ctl_i.evt);
        active = ctl_i.run && legal && priv_ok;

        if (ctl_i.thr == '0) begin
            cond = (cnt_w != '0);
        end else if (ctl_i.flip) begin
            cond = (cnt_w < ctl_i.thr);
        end else begin
            cond = (cnt_w >= ctl_i.thr);
        end

        qual_o = active && cond;

        if (!active) begin
            inc_o = '0;
        end else if (ctl_i.edge_md) begin
            inc_o = (qual_o && !prev_i) ? EVW'(1) : '0;
        end else if (ctl_i.thr == '0) begin
            inc_o = cnt_w;
        end else begin
            inc_o = qual_o ? EVW'(1) : '0;
        end
    end

endmodule

// File: rtl/evtctr_accum.sv
module evtctr_accum #(
    parameter int W  = 40,
    parameter int IW = 4
) (
    input  logic [W-1:0]  cur_i,
    input  logic [IW-1:0] inc_i,
    output logic [W-1:0]  nxt_o,
    output logic          wrap_o
);

    logic [W:0] full_w;

    always_comb begin
        full_w = {1'b0, cur_i} + (W + 1)'(inc_i);
        nxt_o  = full_w[W-1:0];
        wrap_o = full_w[W];
    end

endmodule

// File: rtl/evtctr_unit.sv
module evtctr_unit
    import evtctr_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [1:0]               priv_i,
    input  logic [NCTR*EVW-1:0]      ev_local_i,
    input  logic [NCTR*EVW-1:0]      ev_other_i,
    output logic [NCTR*CODE_W-1:0]   sel_code_o,
    output logic [NCTR*CODE_W-1:0]   sel_umask_o,
    input  logic                     bus_we_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic [BUS_W-1:0]         bus_wdata_i,
    output logic [BUS_W-1:0]         bus_rdata_o,
    output logic [NCTR-1:0]          irq_o
);

    state_t s_d, s_q;

    logic [NCTR-1:0]            qual;
    logic [NCTR-1:0][EVW-1:0]   inc;
    logic [NCTR-1:0][CNT_W-1:0] nxt;
    logic [NCTR-1:0]            wrap;

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        evtctr_qual #(.IDX(g)) i_qual (
            .ctl_i  (s_q.ctl[g]),
            .priv_i (priv_i),
            .loc_i  (ev_local_i[g*EVW +: EVW]),
            .oth_i  (ev_other_i[g*EVW +: EVW]),
            .prev_i (s_q.prev[g]),
            .qual_o (qual[g]),
            .inc_o  (inc[g])
        );

        evtctr_accum #(.W(CNT_W), .IW(EVW)) i_acc (
            .cur_i  (s_q.cnt[g]),
            .inc_i  (inc[g]),
            .nxt_o  (nxt[g]),
            .wrap_o (wrap[g])
        );

        assign sel_code_o[g*CODE_W +: CODE_W]  = s_q.ctl[g].evt;
        assign sel_umask_o[g*CODE_W +: CODE_W] = s_q.ctl[g].mask;
        assign irq_o[g] = s_q.ovf[g] && s_q.ctl[g].irq_en;
    end

    always_comb begin
        logic lo_hit, hi_hit;
        s_d = s_q;
        if (bus_we_i && bus_addr_i == ADDR_W'(ADDR_STAT)) begin
            s_d.ovf = s_q.ovf & ~bus_wdata_i[NCTR-1:0];
        end
        for (int i = 0; i < NCTR; i++) begin
            lo_hit = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_CNT0 + 2 * i));
            hi_hit = bus_we_i && (bus_addr_i == ADDR_W'(ADDR_CNT0 + 2 * i + 1));
            s_d.prev[i] = qual[i];
            if (bus_we_i && bus_addr_i == ADDR_W'(i)) begin
                s_d.ctl[i] = ctl_t'(bus_wdata_i[CTL_W-1:0]);
            end
            if (lo_hit) begin
                s_d.cnt[i][BUS_W-1:0] = bus_wdata_i;
            end else if (hi_hit) begin
                s_d.cnt[i][CNT_W-1:BUS_W] = bus_wdata_i[HI_W-1:0];
            end else begin
                s_d.cnt[i] = nxt[i];
                if (wrap[i]) begin
                    s_d.ovf[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NCTR; i++) begin
            if (bus_addr_i == ADDR_W'(i)) begin
                bus_rdata_o = BUS_W'(s_q.ctl[i]);
            end
            if (bus_addr_i == ADDR_W'(ADDR_CNT0 + 2 * i)) begin
                bus_rdata_o = s_q.cnt[i][BUS_W-1:0];
            end
            if (bus_addr_i == ADDR_W'(ADDR_CNT0 + 2 * i + 1)) begin
                bus_rdata_o = BUS_W'(s_q.cnt[i][CNT_W-1:BUS_W]);
            end
        end
        if (bus_addr_i == ADDR_W'(ADDR_STAT)) begin
            bus_rdata_o = BUS_W'(s_q.ovf);
        end
    end

endmodule

// File: rtl/evtctr_unit_chk.sv
module evtctr_unit_chk
    import evtctr_pkg::*;
(
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       bus_we_i,
    input ctl_t [NCTR-1:0]            ctl_q,
    input logic [NCTR-1:0][CNT_W-1:0] cnt_q,
    input logic [NCTR-1:0]            ovf_q,
    input logic [NCTR-1:0][EVW-1:0]   inc_w
);

    for (genvar g = 0; g < NCTR; g++) begin : g_chk
        // R10
        illegal_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!bus_we_i && !code_allowed(g, ctl_q[g].evt)) |=> $stable(cnt_q[g]));

        // R11
        disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!bus_we_i && !ctl_q[g].run) |=> $stable(cnt_q[g]));

        // R7
        edge_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!bus_we_i && ctl_q[g].edge_md) |=> ((cnt_q[g] - $past(cnt_q[g])) <= CNT_W'(1)));

        // R5
        thr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!bus_we_i && ctl_q[g].thr != '0) |=> ((cnt_q[g] - $past(cnt_q[g])) <= CNT_W'(1)));

        // R12
        wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!bus_we_i && cnt_q[g] == '1 && inc_w[g] != '0) |=> ovf_q[g]);
    end

endmodule

bind evtctr_unit evtctr_unit_chk i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_we_i (bus_we_i),
    .ctl_q    (s_q.ctl),
    .cnt_q    (s_q.cnt),
    .ovf_q    (s_q.ovf),
    .inc_w    (inc)
);

// File: tb/test_evtctr_unit.sv
module test_evtctr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv = '0;
    logic [3:0]  l0 = '0, l1 = '0, o0 = '0, o1 = '0;
    logic [15:0] sel_code, sel_umask;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evtctr_unit i_evtctr_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .priv_i      (priv),
        .ev_local_i  ({l1, l0}),
        .ev_other_i  ({o1, o0}),
        .sel_code_o  (sel_code),
        .sel_umask_o (sel_umask),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 irq, 2 event codes, 3 unit masks
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    function automatic logic [31:0] mk(input logic [7:0] code, input logic [7:0] um,
                                       input logic [3:0] thr, input bit flip, input bit edg,
                                       input bit kern, input bit usr, input bit wide,
                                       input bit ien, input bit run);
        return {5'b0, run, ien, wide, usr, kern, edg, flip, thr, um, code};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input int k, input logic [2:0] a, input logic [31:0] e, input string t);
        item_t it;
        bus_addr = a;
        it.kind = k; it.exp = e; it.tag = t;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic run0(input logic [3:0] v, input int n);
        l0 = v;
        repeat (n) @(negedge clk);
    endtask

    // monitor: samples one ns before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = {30'b0, irq};
                    2:       act = {16'b0, sel_code};
                    default: act = {16'b0, sel_umask};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(0, 3'd6, 32'h0, "R1 status");
        chk(0, 3'd2, 32'h0, "R1 cnt0 low");
        chk(1, 3'd0, 32'h0, "R1 irq");
        chk(2, 3'd0, 32'h0, "R1 codes");

        // R4 R8 full-count add, both level bits clear
        wr(3'd0, mk(8'hC0, 8'h5A, 4'd0, 0, 0, 0, 0, 0, 0, 1));
        chk(2, 3'd0, 32'h0000_00C0, "R3 sel code");
        chk(3, 3'd0, 32'h0000_005A, "R3 sel umask");
        chk(0, 3'd0, mk(8'hC0, 8'h5A, 4'd0, 0, 0, 0, 0, 0, 0, 1), "R2 ctl0 readback");
        priv = 2'd0; run0(4'd3, 3);
        priv = 2'd3; run0(4'd5, 2);
        l0 = 0; priv = 2'd0;
        chk(0, 3'd2, 32'd19, "R4 R8 full count");
        wr(3'd0, 32'h0);

        // R5 threshold
        wr(3'd2, 32'h0);
        wr(3'd0, mk(8'hC0, 8'h00, 4'd4, 0, 0, 0, 0, 0, 0, 1));
        run0(4'd3, 1); run0(4'd4, 1); run0(4'd5, 1); run0(4'd2, 1); run0(4'd7, 1);
        l0 = 0;
        chk(0, 3'd2, 32'd3, "R5 threshold");

        // R6 inverted threshold
        wr(3'd2, 32'h0);
        wr(3'd0, mk(8'hC0, 8'h00, 4'd4, 1, 0, 0, 0, 0, 0, 1));
        run0(4'd3, 1); run0(4'd4, 1); run0(4'd5, 1); run0(4'd2, 1); run0(4'd7, 1);
        l0 = 4'd9;
        wr(3'd0, 32'h0);
        l0 = 0;
        chk(0, 3'd2, 32'd2, "R6 invert");

        // R7 edge
        wr(3'd2, 32'h0);
        wr(3'd0, mk(8'hC0, 8'h00, 4'd4, 0, 1, 0, 0, 0, 0, 1));
        run0(4'd5, 3); run0(4'd0, 1); run0(4'd6, 2); run0(4'd0, 2); run0(4'd7, 1);
        l0 = 0;
        chk(0, 3'd2, 32'd3, "R7 edge");
        wr(3'd0, 32'h0);

        // R8 privilege filter
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd0, mk(8'hC0, 8'h00, 4'd0, 0, 0, 1, 0, 0, 0, 1));
        wr(3'd1, mk(8'h10, 8'h00, 4'd0, 0, 0, 0, 1, 0, 0, 1));
        l0 = 2; l1 = 2; priv = 2'd0;
        repeat (3) @(negedge clk);
        priv = 2'd2;
        repeat (3) @(negedge clk);
        l0 = 0; l1 = 0; priv = 2'd0;
        chk(0, 3'd2, 32'd6, "R8 kernel only");
        chk(0, 3'd4, 32'd6, "R8 user only");
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);

        // R9 all cores
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd0, mk(8'hC0, 8'h00, 4'd0, 0, 0, 0, 0, 1, 0, 1));
        wr(3'd1, mk(8'h10, 8'h00, 4'd0, 0, 0, 0, 0, 0, 0, 1));
        l0 = 2; o0 = 3; l1 = 2; o1 = 3;
        repeat (4) @(negedge clk);
        l0 = 9; o0 = 9; l1 = 9; o1 = 9;
        @(negedge clk);
        l0 = 0; o0 = 0; l1 = 0; o1 = 0;
        chk(0, 3'd2, 32'd35, "R9 all cores saturating");
        chk(0, 3'd4, 32'd17, "R9 this core");
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);

        // R10 restricted codes
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd0, mk(8'h13, 8'h00, 4'd0, 0, 0, 0, 0, 0, 0, 1));
        wr(3'd1, mk(8'h14, 8'h00, 4'd0, 0, 0, 0, 0, 0, 0, 1));
        l0 = 3; l1 = 3;
        repeat (4) @(negedge clk);
        l0 = 0; l1 = 0;
        chk(0, 3'd2, 32'd0, "R10 code 13H on counter 0");
        chk(0, 3'd4, 32'd0, "R10 code 14H on counter 1");
        wr(3'd0, mk(8'h14, 8'h00, 4'd0, 0, 0, 0, 0, 0, 0, 1));
        wr(3'd1, mk(8'h13, 8'h00, 4'd0, 0, 0, 0, 0, 0, 0, 1));
        l0 = 3; l1 = 3;
        repeat (4) @(negedge clk);
        l0 = 0; l1 = 0;
        chk(0, 3'd2, 32'd12, "R10 code 14H on counter 0");
        chk(0, 3'd4, 32'd12, "R10 code 13H on counter 1");
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);

        // R11 disabled counter holds
        l0 = 5;
        repeat (3) @(negedge clk);
        l0 = 0;
        chk(0, 3'd2, 32'd12, "R11 run clear holds");

        // R12 wrap, sticky status, interrupt
        wr(3'd3, 32'h0000_00FF);
        wr(3'd2, 32'hFFFF_FFFE);
        chk(0, 3'd3, 32'h0000_00FF, "R2 cnt0 high readback");
        wr(3'd0, mk(8'hC0, 8'h00, 4'd0, 0, 0, 0, 0, 0, 1, 1));
        run0(4'd1, 3);
        l0 = 0;
        chk(0, 3'd2, 32'd1, "R12 wrap low");
        chk(0, 3'd3, 32'd0, "R12 wrap high");
        chk(0, 3'd6, 32'd1, "R12 status set");
        chk(1, 3'd0, 32'd1, "R12 irq raised");
        wr(3'd5, 32'h0000_00FF);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd1, mk(8'h10, 8'h00, 4'd0, 0, 0, 0, 0, 0, 0, 1));
        l1 = 1;
        @(negedge clk);
        l1 = 0;
        chk(0, 3'd6, 32'd3, "R12 status both");
        chk(1, 3'd0, 32'd1, "R12 irq masked on counter 1");
        wr(3'd6, 32'd1);
        chk(0, 3'd6, 32'd2, "R12 clear bit 0");
        chk(1, 3'd0, 32'd0, "R12 irq dropped");
        wr(3'd6, 32'd2);
        chk(0, 3'd6, 32'd0, "R12 clear bit 1");
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);

        // R13 write beats increment
        wr(3'd0, mk(8'hC0, 8'h00, 4'd0, 0, 0, 0, 0, 0, 0, 1));
        l0 = 4;
        repeat (2) @(negedge clk);
        wr(3'd2, 32'd100);
        repeat (2) @(negedge clk);
        l0 = 0;
        chk(0, 3'd2, 32'd108, "R13 write priority");
        wr(3'd0, 32'h0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule